// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block serves one DMA channel in normal transfer mode. An external device asks for service by pulling an active-low request line. The line passes through a two-flop synchronizer and is then sampled on every clock edge. A low level that is sampled while the channel can accept requests sets a held pending flag. When the sequencer activates, it clears that flag. After a fixed arbitration gap, it performs one bus read from the source address, followed by one bus write of the captured data to the destination address. Both addresses increase by one after each transfer.

From activation until the write is acknowledged, requests are masked. An optional delay bit keeps the mask up for one more cycle after the write. Once the mask lifts, a new transfer needs a fresh low level at a sampling edge. This repeats until the programmed transfer count runs out. At that point the channel disables itself and emits a one-cycle completion pulse. Software programs the enable bit, the delay bit, the count and both base addresses in one configuration write.

Top module: `dma_level_req_ctrl`

## Requirements
- R1: After reset the read strobe, write strobe and completion pulse are low, and a low request line causes no bus activity while the channel is disabled.
- R2: Request sampling begins at the first clock edge after the configuration-write cycle that sets the enable bit. With the line already low, the read strobe is first seen 5 cycles after the write cycle.
- R3: The request line passes two synchronizer flops before sampling. The read strobe is first seen 6 cycles after the line falls, and at least 3 cycles after the pending flag is set.
- R4: Each serviced request performs one read at the source address, then one write of the read data to the destination address. Both addresses start at their programmed bases and step by one per transfer. The two strobes are never high together.
- R5: The pending flag is cleared at activation. With the line held low and the delay bit 0, consecutive read starts are 6 cycles apart.
- R6: A low level on the line while the channel is masked (from activation to write completion) is ignored and queues no second transfer.
- R7: With the delay bit 1, request acceptance resumes one cycle later, so consecutive read starts under a held-low line are 7 cycles apart.
- R8: The count decrements on each write acknowledge. The acknowledge that takes it to zero clears the enable bit and raises the completion output for exactly one cycle, in the cycle after that acknowledge. No further transfers follow.
- R9: Clearing the enable bit during a transfer lets the current read/write pair finish but starts no new one.
- R10: Writing the enable bit with a transfer count of zero leaves the channel disabled.
- R11: The read strobe stays high until the read done input is seen, including when the slave inserts wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Channel enable value |
| cfgExtDelay | input | 1 | Extend request mask by one cycle after each write |
| cfgCount | input | CNT_W | Number of transfers |
| cfgSrcBase | input | ADDR_W | Source start address |
| cfgDstBase | input | ADDR_W | Destination start address |
| reqN | input | 1 | Asynchronous active-low transfer request |
| rdStrobe | output | 1 | Read cycle request |
| rdAddr | output | ADDR_W | Read address |
| rdDone | input | 1 | Read acknowledge with data valid |
| rdData | input | DATA_W | Read data |
| wrStrobe | output | 1 | Write cycle request |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | DATA_W | Write data |
| wrDone | input | 1 | Write acknowledge |
| xferDone | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
On every cycle, the embedded assertions check the following: the two strobes are mutually exclusive, a write only follows a read, the read strobe holds through wait cycles, no request is held while the channel is masked, the pending flag empties on activation, the flag has aged at least three cycles before a read begins, and the completion pulse is one cycle wide and leaves the channel disabled. Only the bench scenarios can show the exact cycle counts: 5 cycles from the enable write, 6 from a falling line, and read-to-read spacings of 6 and 7 for the two delay settings. The scenarios also show that a low pulse during the mask is dropped, that a mid-transfer disable finishes its pair, and that the transferred data and addresses match the scoreboard.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_READ,
    ST_WRITE,
    ST_HOLD
  } ctrlState_t;

  typedef struct packed {
    logic captureRd;
    logic advance;
  } dpStrobe_t;

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ARB_CYCLES  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqN,
  input  logic      enableQ,
  input  logic      extDelayQ,
  input  logic      rdDone,
  input  logic      wrDone,
  output logic      rdStrobe,
  output logic      wrStrobe,
  output dpStrobe_t dpCtl
);

  localparam int ARB_W = $clog2(ARB_CYCLES + 1);

  ctrlState_t               state;
  logic                     pending;
  logic [ARB_W-1:0]         arbCnt;
  logic [SYNC_STAGES-1:0]   syncQ;
  logic                     reqLow;

  // request synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], reqN};
  end
  assign reqLow = !syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      arbCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!enableQ) begin
            pending <= 1'b0;
          end else if (pending) begin
            pending <= 1'b0;
            state   <= ST_ARB;
            arbCnt  <= ARB_W'(ARB_CYCLES - 1);
          end else if (reqLow) begin
            pending <= 1'b1;
          end
        end
        ST_ARB: begin
          if (arbCnt == '0) state <= ST_READ;
          else              arbCnt <= arbCnt - 1'b1;
        end
        ST_READ:  if (rdDone) state <= ST_WRITE;
        ST_WRITE: if (wrDone) state <= extDelayQ ? ST_HOLD : ST_IDLE;
        ST_HOLD:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign rdStrobe        = (state == ST_READ);
  assign wrStrobe        = (state == ST_WRITE);
  assign dpCtl.captureRd = rdStrobe && rdDone;
  assign dpCtl.advance   = wrStrobe && wrDone;

  // age of the held request, for the latency check
  logic       pendPrev;
  logic [3:0] heldAge;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPrev <= 1'b0;
      heldAge  <= '0;
    end else begin
      pendPrev <= pending;
      if (pending && !pendPrev) heldAge <= 4'd1;
      else if (heldAge != 4'hF) heldAge <= heldAge + 4'd1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe)); // R4
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStrobe) |-> $past(rdStrobe) && $past(rdDone)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !rdDone) |=> rdStrobe); // R11
  AST_NO_PEND_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !pending); // R6
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ARB) |-> !pending); // R5
  AST_ARB_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe) |-> heldAge >= 4'd3); // R3

endmodule

// File: rtl/dma_req_datapath.sv
module dma_req_datapath
  import dma_req_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgEnable,
  input  logic              cfgExtDelay,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgSrcBase,
  input  logic [ADDR_W-1:0] cfgDstBase,
  input  dpStrobe_t         dpCtl,
  input  logic [DATA_W-1:0] rdData,
  output logic              enableQ,
  output logic              extDelayQ,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              xferDone
);

  logic [CNT_W-1:0]  countQ;
  logic [ADDR_W-1:0] srcQ;
  logic [ADDR_W-1:0] dstQ;
  logic [DATA_W-1:0] dataQ;
  logic              doneQ;
  logic              lastXfer;

  assign lastXfer = (countQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      extDelayQ <= 1'b0;
      countQ    <= '0;
      srcQ      <= '0;
      dstQ      <= '0;
      dataQ     <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cfgWrEn) begin
        enableQ   <= cfgEnable && (cfgCount != '0);
        extDelayQ <= cfgExtDelay;
        countQ    <= cfgCount;
        srcQ      <= cfgSrcBase;
        dstQ      <= cfgDstBase;
      end else if (dpCtl.advance) begin
        if (countQ != '0) countQ <= countQ - 1'b1;
        srcQ <= srcQ + 1'b1;
        dstQ <= dstQ + 1'b1;
        if (lastXfer) begin
          enableQ <= 1'b0;
          doneQ   <= 1'b1;
        end
      end
      if (dpCtl.captureRd) dataQ <= rdData;
    end
  end

  assign rdAddr   = srcQ;
  assign wrAddr   = dstQ;
  assign wrData   = dataQ;
  assign xferDone = doneQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone); // R8
  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (!enableQ || $past(cfgWrEn))); // R8

endmodule

// File: rtl/dma_level_req_ctrl.sv
module dma_level_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ARB_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgEnable,
  input  logic              cfgExtDelay,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgSrcBase,
  input  logic [ADDR_W-1:0] cfgDstBase,
  input  logic              reqN,
  output logic              rdStrobe,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdDone,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrDone,
  output logic              xferDone
);

  dpStrobe_t dpCtl;
  logic      enableQ;
  logic      extDelayQ;

  dma_req_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .ARB_CYCLES (ARB_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqN     (reqN),
    .enableQ  (enableQ),
    .extDelayQ(extDelayQ),
    .rdDone   (rdDone),
    .wrDone   (wrDone),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .dpCtl    (dpCtl)
  );

  dma_req_datapath #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgEnable  (cfgEnable),
    .cfgExtDelay(cfgExtDelay),
    .cfgCount   (cfgCount),
    .cfgSrcBase (cfgSrcBase),
    .cfgDstBase (cfgDstBase),
    .dpCtl      (dpCtl),
    .rdData     (rdData),
    .enableQ    (enableQ),
    .extDelayQ  (extDelayQ),
    .rdAddr     (rdAddr),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .xferDone   (xferDone)
  );

endmodule

// File: tb/tb_dma_level_req_ctrl.sv
`timescale 1ns/1ps
module tb_dma_level_req_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgEnable = 1'b0;
  logic        cfgExtDelay = 1'b0;
  logic [7:0]  cfgCount = '0;
  logic [15:0] cfgSrcBase = '0;
  logic [15:0] cfgDstBase = '0;
  logic        reqN = 1'b1;
  logic        rdStrobe;
  logic [15:0] rdAddr;
  logic        rdDone = 1'b0;
  logic [15:0] rdData = '0;
  logic        wrStrobe;
  logic [15:0] wrAddr;
  logic [15:0] wrData;
  logic        wrDone = 1'b0;
  logic        xferDone;

  dma_level_req_ctrl dut (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [15:0] src; logic [15:0] dst; logic [15:0] data; } item_t;
  item_t sb[$];
  int rdStartCyc[$];
  int nReads = 0, nWrites = 0, doneCnt = 0;
  int doneCyc = 0, lastWrCyc = 0, rdDoneCyc = 0;
  int rdWait = 0;
  int nChecks = 0, nFails = 0;

  function automatic logic [15:0] memVal(input logic [15:0] a);
    return (a * 16'd29) ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushExpected(input int n, input logic [15:0] src, input logic [15:0] dst);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.src  = src + 16'(i);
      it.dst  = dst + 16'(i);
      it.data = memVal(src + 16'(i));
      sb.push_back(it);
    end
  endtask

  task automatic cfgWrite(input bit en, input bit ext, input logic [7:0] cnt,
                          input logic [15:0] src, input logic [15:0] dst, output int c);
    @(negedge clk);
    c = cyc;
    cfgWrEn = 1'b1; cfgEnable = en; cfgExtDelay = ext;
    cfgCount = cnt; cfgSrcBase = src; cfgDstBase = dst;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // bus slave, scoreboard monitor
  initial begin
    bit rdSeen = 0;
    int waitLeft = 0;
    forever begin
      @(negedge clk);
      rdDone = 1'b0;
      wrDone = 1'b0;
      if (rdStrobe) begin
        if (!rdSeen) begin
          rdSeen = 1;
          rdStartCyc.push_back(cyc);
          nReads++;
          waitLeft = rdWait;
          if (sb.size() == 0) check(0, "R4", "unexpected read", rdAddr, -1);
          else check(rdAddr == sb[0].src, "R4", "read address", rdAddr, sb[0].src);
        end
        if (waitLeft == 0) begin
          rdDone = 1'b1;
          rdData = memVal(rdAddr);
          rdDoneCyc = cyc;
          rdSeen = 0;
        end else waitLeft--;
      end else if (rdSeen) begin
        check(0, "R11", "read strobe dropped early", 0, 1);
        rdSeen = 0;
      end
      if (wrStrobe) begin
        if (sb.size() == 0) check(0, "R4", "unexpected write", wrAddr, -1);
        else begin
          check(wrAddr == sb[0].dst, "R4", "write address", wrAddr, sb[0].dst);
          check(wrData == sb[0].data, "R4", "write data", wrData, sb[0].data);
          void'(sb.pop_front());
        end
        wrDone = 1'b1;
        lastWrCyc = cyc;
        nWrites++;
      end
      if (xferDone) begin
        doneCnt++;
        doneCyc = cyc;
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 60000);
    check(0, "WATCHDOG", "timeout", cyc, 0);
    finishRun();
  end

  initial begin
    int c, r0, w0, d0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdStrobe == 0, "R1", "rdStrobe after reset", rdStrobe, 0);
    check(wrStrobe == 0, "R1", "wrStrobe after reset", wrStrobe, 0);
    check(xferDone == 0, "R1", "xferDone after reset", xferDone, 0);
    reqN = 1'b0;
    idle(12);
    check(nReads == 0, "R1", "reads while disabled", nReads, 0);

    // R10 zero count leaves channel disabled
    cfgWrite(1, 0, 8'd0, 16'h0040, 16'h0080, c);
    idle(20);
    check(nReads == 0, "R10", "reads with zero count", nReads, 0);

    // R2 enable timing, R5 held-low spacing, R8 completion
    pushExpected(3, 16'h0100, 16'h0200);
    r0 = nReads;
    cfgWrite(1, 0, 8'd3, 16'h0100, 16'h0200, c);
    wait (nReads == r0 + 1);
    check(rdStartCyc[r0] - c == 5, "R2", "cycles from enable write to read", rdStartCyc[r0] - c, 5);
    wait (doneCnt == 1);
    @(negedge clk);
    check(rdStartCyc[r0 + 1] - rdStartCyc[r0] == 6, "R5", "read spacing delay off", rdStartCyc[r0 + 1] - rdStartCyc[r0], 6);
    check(rdStartCyc[r0 + 2] - rdStartCyc[r0 + 1] == 6, "R5", "read spacing delay off", rdStartCyc[r0 + 2] - rdStartCyc[r0 + 1], 6);
    check(doneCyc == lastWrCyc + 1, "R8", "done pulse cycle", doneCyc, lastWrCyc + 1);
    idle(20);
    check(nReads == r0 + 3, "R8", "reads after count exhausted", nReads, r0 + 3);
    check(doneCnt == 1, "R8", "done pulse count", doneCnt, 1);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);

    // R7 extended mask
    pushExpected(3, 16'h0300, 16'h0400);
    r0 = nReads;
    cfgWrite(1, 1, 8'd3, 16'h0300, 16'h0400, c);
    wait (doneCnt == 2);
    @(negedge clk);
    check(rdStartCyc[r0 + 1] - rdStartCyc[r0] == 7, "R7", "read spacing delay on", rdStartCyc[r0 + 1] - rdStartCyc[r0], 7);
    check(rdStartCyc[r0 + 2] - rdStartCyc[r0 + 1] == 7, "R7", "read spacing delay on", rdStartCyc[r0 + 2] - rdStartCyc[r0 + 1], 7);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
    reqN = 1'b1;
    idle(6);

    // R6 low pulse during mask ignored, R11 read wait states
    pushExpected(2, 16'h0600, 16'h0700);
    cfgWrite(1, 0, 8'd2, 16'h0600, 16'h0700, c);
    idle(3);
    rdWait = 6;
    r0 = nReads; w0 = nWrites; d0 = doneCnt;
    @(negedge clk);
    reqN = 1'b0;
    wait (nReads == r0 + 1);
    @(negedge clk);
    reqN = 1'b1;
    idle(1);
    reqN = 1'b0;
    idle(2);
    reqN = 1'b1;
    idle(30);
    check(nReads == r0 + 1, "R6", "reads after masked pulse", nReads, r0 + 1);
    check(nWrites == w0 + 1, "R6", "writes after masked pulse", nWrites, w0 + 1);
    check(rdDoneCyc - rdStartCyc[r0] == 6, "R11", "read strobe length", rdDoneCyc - rdStartCyc[r0], 6);
    check(doneCnt == d0, "R8", "no done before count exhausted", doneCnt, d0);

    // R3 latency from falling line
    rdWait = 0;
    @(negedge clk);
    c = cyc;
    reqN = 1'b0;
    wait (nReads == r0 + 2);
    check(rdStartCyc[r0 + 1] - c == 6, "R3", "cycles from request fall to read", rdStartCyc[r0 + 1] - c, 6);
    reqN = 1'b1;
    idle(10);
    check(doneCnt == d0 + 1, "R8", "done after last transfer", doneCnt, d0 + 1);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);

    // R9 disable mid-transfer
    pushExpected(1, 16'h0900, 16'h0A00);
    r0 = nReads; w0 = nWrites; d0 = doneCnt;
    reqN = 1'b0;
    cfgWrite(1, 0, 8'd4, 16'h0900, 16'h0A00, c);
    wait (nReads == r0 + 1);
    cfgWrite(0, 0, 8'd4, 16'h0900, 16'h0A00, c);
    idle(30);
    check(nWrites == w0 + 1, "R9", "current pair finished", nWrites, w0 + 1);
    check(nReads == r0 + 1, "R9", "no new read after disable", nReads, r0 + 1);
    check(doneCnt == d0, "R9", "no done pulse after disable", doneCnt, d0);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
    reqN = 1'b1;
    idle(4);
    finishRun();
  end

endmodule